// File: doc/BRIEF.md
# CPU Clock Source and Divider Select

This block sets the CPU clock rate of a small microcontroller from one 8-bit control register on a simple CPU bus. Each CPU clock is a single-cycle enable pulse, called `cpu_clk_en`. The enables come from one of two sources. The first is the main oscillator, here the block's own `clk`, divided by 1, 2, 4, 8, 16 or 32. The second is an external low-speed subclock tick. The block reports which source is active, and it gates the main oscillator run request so that the oscillator stops only once the CPU no longer depends on it.

Writes to the control register are guarded by a key sequence. A write to a key address must come directly before the control write. An unguarded control write is discarded and latches an error flag. A new source or divider takes effect only when the current divided period completes, so no enable period is ever cut short. While the clock-output pin is enabled, the source and divider field is frozen.

Top module: `cpu_clk_sel`

## Requirements
- R1: After reset the control register reads 0x03, `prot_err` is 0, `main_osc_run` is 1, and `cpu_clk_en` pulses once every 8 cycles.
- R2: The register layout is: bit 7 subclock feedback select, bit 6 main stop request (STOP), bit 5 main feedback select, bit 4 active-source status (SRC), and bits 3:0 the select field SEL. A write changes only the bits set in `bus_wmask`, so both a full byte write (mask 0xFF) and a single-bit write (one-hot mask) work. Bits 7 and 5 are plain storage.
- R3: With SEL[3]=0, the code SEL[2:0]=k (k from 0 to 5) gives an enable period of 2^k cycles.
- R4: A write whose resulting SEL has SEL[3]=0 and SEL[2:0] equal to 6 or 7 leaves SEL at its previous value. The other bits of that write still take effect.
- R5: With SEL[3]=1, `cpu_clk_en` equals `sub_tick` in every cycle, and SEL[2:0] has no effect.
- R6: SRC reads 0 while the main clock is active and 1 while the subclock is active. Writes to bit 4 have no effect.
- R7: Setting STOP while the main clock is active keeps `main_osc_run` at 1. `main_osc_run` drops to 0 only once SRC is 1.
- R8: Clearing STOP raises `main_osc_run` in the cycle after the write.
- R9: A control write (address 0) that does not directly follow a key write (address 1) is discarded and sets `prot_err`. `prot_err` stays set until reset.
- R10: Any bus read or write between the key write and the control write disarms the key, so the control write is discarded.
- R11: A change of SEL takes effect only at the enable pulse that ends the current period. No shortened period occurs.
- R12: While `clkout_en` is 1, SEL does not change. Other bits of the write still apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Bus write strobe, one cycle per access |
| bus_rd | input | 1 | Bus read strobe, one cycle per access |
| bus_addr | input | 1 | 0 selects the control register, 1 selects the key register |
| bus_wdata | input | 8 | Write data |
| bus_wmask | input | 8 | Per-bit write enable |
| bus_rdata | output | 8 | Control register image when `bus_addr` is 0, otherwise 0 |
| clkout_en | input | 1 | Clock-output pin enabled; freezes SEL |
| sub_tick | input | 1 | One-cycle subclock tick |
| cpu_clk_en | output | 1 | CPU clock enable pulse |
| main_osc_run | output | 1 | Main oscillator run request |
| prot_err | output | 1 | Sticky guarded-write violation flag |

## Verification
A control write is registered on the edge that ends its bus cycle. `bus_rdata`, `prot_err` and `main_osc_run` therefore show the result at the first falling edge after that, and the bench samples them there. A SEL change reaches `cpu_clk_en` only after the running period ends. For that reason the bench measures the gaps between pulses: it takes the second gap after a write as the settled rate, and it counts the boundary case from a known pulse. In subclock mode `cpu_clk_en` is combinational from `sub_tick`, so the bench samples it one time step after driving the tick.

// File: rtl/cks_pkg.sv
package cks_pkg;
    localparam logic ADDR_CTL = 1'b0;
    localparam logic ADDR_KEY = 1'b1;

    typedef struct packed {
        logic       frc_sub;
        logic       stop;
        logic       frc_main;
        logic [3:0] sel;
    } ctl_t;

    localparam ctl_t CTL_RST = '{frc_sub: 1'b0, stop: 1'b0, frc_main: 1'b0, sel: 4'b0011};

    typedef struct packed {
        logic armed;
        logic err;
    } guard_t;
endpackage

// File: rtl/cks_guard.sv
module cks_guard
    import cks_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_wr,
    input  logic bus_rd,
    input  logic bus_addr,
    output logic wr_ok,
    output logic armed,
    output logic err
);
    guard_t g_d, g_q;

    always_comb begin
        g_d   = g_q;
        wr_ok = 1'b0;
        if (bus_wr || bus_rd) begin
            if (bus_wr && bus_addr == ADDR_KEY) begin
                g_d.armed = 1'b1;
            end else begin
                g_d.armed = 1'b0;
                if (bus_wr && bus_addr == ADDR_CTL) begin
                    if (g_q.armed) wr_ok = 1'b1;
                    else           g_d.err = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign armed = g_q.armed;
    assign err   = g_q.err;
endmodule

// File: rtl/cks_regs.sv
module cks_regs
    import cks_pkg::*;
#(
    parameter int DIV_LOG_MAX = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ok,
    input  logic [7:0] wdata,
    input  logic [7:0] wmask,
    input  logic       clkout_en,
    output ctl_t       ctl
);
    localparam logic [2:0] MAX_CODE = 3'(DIV_LOG_MAX);

    ctl_t       c_d, c_q;
    logic [7:0] img;
    logic [7:0] merged;
    logic       unused_src_bit;

    assign img = {c_q.frc_sub, c_q.stop, c_q.frc_main, 1'b0, c_q.sel};

    for (genvar b = 0; b < 8; b++) begin : g_merge
        assign merged[b] = wmask[b] ? wdata[b] : img[b];
    end

    assign unused_src_bit = merged[4];

    always_comb begin
        c_d = c_q;
        if (wr_ok) begin
            c_d.frc_sub  = merged[7];
            c_d.stop     = merged[6];
            c_d.frc_main = merged[5];
            if (!clkout_en && (merged[3] || merged[2:0] <= MAX_CODE))
                c_d.sel = merged[3:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= CTL_RST;
        else        c_q <= c_d;
    end

    assign ctl = c_q;
endmodule

// File: rtl/cks_div.sv
module cks_div
    import cks_pkg::*;
#(
    parameter int DIV_LOG_MAX = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] sel_req,
    input  logic       sub_tick,
    output logic       pulse,
    output logic [3:0] act_sel
);
    localparam int CNT_W = DIV_LOG_MAX;

    typedef struct packed {
        logic [3:0]       act;
        logic [CNT_W-1:0] cnt;
    } div_t;

    div_t             s_d, s_q;
    logic [CNT_W-1:0] lim;

    always_comb begin
        lim   = CNT_W'((32'd1 << s_q.act[2:0]) - 32'd1);
        pulse = s_q.act[3] ? sub_tick : (s_q.cnt == lim);
        s_d   = s_q;
        if (s_q.act[3] || pulse) s_d.cnt = '0;
        else                     s_d.cnt = s_q.cnt + CNT_W'(1);
        if (pulse) s_d.act = sel_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{act: CTL_RST.sel, cnt: '0};
        else        s_q <= s_d;
    end

    assign act_sel = s_q.act;
endmodule

// File: rtl/cpu_clk_sel.sv
module cpu_clk_sel
    import cks_pkg::*;
#(
    parameter int DIV_LOG_MAX = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic [7:0] bus_wmask,
    output logic [7:0] bus_rdata,
    input  logic       clkout_en,
    input  logic       sub_tick,
    output logic       cpu_clk_en,
    output logic       main_osc_run,
    output logic       prot_err
);
    logic       wr_ok;
    logic       key_armed;
    ctl_t       ctl;
    logic [3:0] act_sel;
    logic [3:0] sel_q;
    logic       src_sub;
    logic       stop_q;

    cks_guard u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .wr_ok    (wr_ok),
        .armed    (key_armed),
        .err      (prot_err)
    );

    cks_regs #(.DIV_LOG_MAX(DIV_LOG_MAX)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ok     (wr_ok),
        .wdata     (bus_wdata),
        .wmask     (bus_wmask),
        .clkout_en (clkout_en),
        .ctl       (ctl)
    );

    cks_div #(.DIV_LOG_MAX(DIV_LOG_MAX)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_req  (ctl.sel),
        .sub_tick (sub_tick),
        .pulse    (cpu_clk_en),
        .act_sel  (act_sel)
    );

    assign sel_q        = ctl.sel;
    assign stop_q       = ctl.stop;
    assign src_sub      = act_sel[3];
    assign main_osc_run = !(stop_q && src_sub);
    assign bus_rdata    = (bus_addr == ADDR_CTL)
                        ? {ctl.frc_sub, ctl.stop, ctl.frc_main, src_sub, ctl.sel}
                        : 8'h00;
endmodule

// File: rtl/cks_chk.sv
module cks_chk
    import cks_pkg::*;
#(
    parameter int DIV_LOG_MAX = 5
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic       bus_addr,
    input logic       clkout_en,
    input logic       prot_err,
    input logic       key_armed,
    input logic [3:0] sel_q,
    input logic [3:0] act_sel,
    input logic       cpu_clk_en,
    input logic       src_sub,
    input logic       main_osc_run
);
    localparam logic [2:0] MAX_CODE = 3'(DIV_LOG_MAX);

    p_sel_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q[3] || (sel_q[2:0] <= MAX_CODE));

    p_osc_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !src_sub |-> main_osc_run);

    p_drop_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_CTL && !key_armed) |=> prot_err);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        prot_err |=> prot_err);

    p_disarm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr || bus_rd) && !(bus_wr && bus_addr == ADDR_KEY)) |=> !key_armed);

    p_switch_at_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_clk_en |=> $stable(act_sel));

    p_sel_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
        clkout_en |=> $stable(sel_q));
endmodule

bind cpu_clk_sel cks_chk #(.DIV_LOG_MAX(DIV_LOG_MAX)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_addr     (bus_addr),
    .clkout_en    (clkout_en),
    .prot_err     (prot_err),
    .key_armed    (key_armed),
    .sel_q        (sel_q),
    .act_sel      (act_sel),
    .cpu_clk_en   (cpu_clk_en),
    .src_sub      (src_sub),
    .main_osc_run (main_osc_run)
);

// File: tb/cpu_clk_sel_test.sv
module cpu_clk_sel_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_wmask = 8'h00;
    logic [7:0] bus_rdata;
    logic       clkout_en = 1'b0;
    logic       sub_tick = 1'b0;
    logic       cpu_clk_en;
    logic       main_osc_run;
    logic       prot_err;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    cpu_clk_sel uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_wmask    (bus_wmask),
        .bus_rdata    (bus_rdata),
        .clkout_en    (clkout_en),
        .sub_tick     (sub_tick),
        .cpu_clk_en   (cpu_clk_en),
        .main_osc_run (main_osc_run),
        .prot_err     (prot_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_cycle(input logic wr, input logic rd, input logic addr,
                             input logic [7:0] data, input logic [7:0] mask);
        bus_wr = wr; bus_rd = rd; bus_addr = addr; bus_wdata = data; bus_wmask = mask;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 1'b0; bus_wdata = 8'h00; bus_wmask = 8'h00;
    endtask

    task automatic ctl_write(input logic [7:0] data, input logic [7:0] mask);
        bus_cycle(1'b1, 1'b0, 1'b1, 8'h00, 8'h00);
        bus_cycle(1'b1, 1'b0, 1'b0, data, mask);
    endtask

    task automatic gap_to_pulse(output int g);
        g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!cpu_clk_en && g < 300);
    endtask

    task automatic measure_gap(output int g);
        int w;
        gap_to_pulse(w);
        gap_to_pulse(g);
    endtask

    task automatic t_reset;
        int g;
        chk("R1 rdata", bus_rdata, 8'h03);
        chk("R1 prot_err", prot_err, 0);
        chk("R1 osc run", main_osc_run, 1);
        measure_gap(g);
        chk("R1 period", g, 8);
    endtask

    task automatic t_divs;
        int g;
        for (int k = 0; k < 6; k++) begin
            ctl_write(8'(k), 8'h0F);
            chk("R3 rdata", bus_rdata, 32'(k));
            measure_gap(g);
            measure_gap(g);
            chk("R3 period", g, 32'd1 << k);
        end
    endtask

    task automatic t_prohibited;
        int g;
        ctl_write(8'h22, 8'hFF);
        chk("R4 legal set", bus_rdata, 8'h22);
        ctl_write(8'h06, 8'hFF);
        chk("R4 code 6 kept", bus_rdata, 8'h02);
        measure_gap(g);
        measure_gap(g);
        chk("R4 period kept", g, 4);
        ctl_write(8'h87, 8'h8F);
        chk("R4 code 7 kept", bus_rdata, 8'h82);
    endtask

    task automatic t_bitwise;
        ctl_write(8'hFF, 8'h20);
        chk("R2 bit5 set", bus_rdata, 8'hA2);
        ctl_write(8'h00, 8'h80);
        chk("R2 bit7 clear", bus_rdata, 8'h22);
        ctl_write(8'h00, 8'h20);
        chk("R2 bit5 clear", bus_rdata, 8'h02);
        ctl_write(8'h01, 8'h01);
        chk("R2 sel bit0 set", bus_rdata, 8'h03);
        ctl_write(8'hFF, 8'h10);
        chk("R6 src write ignored", bus_rdata, 8'h03);
    endtask

    task automatic t_subclock;
        int g;
        int cnt;
        ctl_write(8'h40, 8'h40);
        chk("R7 stop set", bus_rdata, 8'h43);
        chk("R7 osc kept on main", main_osc_run, 1);
        ctl_write(8'h0B, 8'h0F);
        chk("R11 src not yet", bus_rdata, 8'h4B);
        chk("R7 osc kept before switch", main_osc_run, 1);
        repeat (9) @(negedge clk);
        chk("R6 src reads sub", bus_rdata, 8'h5B);
        chk("R7 osc stopped", main_osc_run, 0);
        cnt = 0;
        for (int i = 0; i < 20; i++) begin
            sub_tick = (i % 5 == 0);
            #1;
            if (cpu_clk_en) cnt++;
            @(negedge clk);
        end
        sub_tick = 1'b0;
        chk("R5 follows sub_tick", cnt, 4);
        ctl_write(8'h00, 8'h10);
        chk("R6 src clear ignored", bus_rdata, 8'h5B);
        ctl_write(8'h00, 8'h40);
        chk("R8 osc restart", main_osc_run, 1);
        chk("R8 rdata", bus_rdata, 8'h1B);
        ctl_write(8'h00, 8'h0F);
        chk("R5 wait for tick", bus_rdata, 8'h10);
        sub_tick = 1'b1;
        @(negedge clk);
        sub_tick = 1'b0;
        chk("R6 back on main", bus_rdata, 8'h00);
        measure_gap(g);
        chk("R3 undivided", g, 1);
    endtask

    task automatic t_boundary;
        int g;
        ctl_write(8'h05, 8'h0F);
        measure_gap(g);
        chk("R11 slow period", g, 32);
        ctl_write(8'h00, 8'h0F);
        gap_to_pulse(g);
        chk("R11 old period completes", g + 2, 32);
        gap_to_pulse(g);
        chk("R11 new period", g, 1);
    endtask

    task automatic t_clkout;
        int g;
        clkout_en = 1'b1;
        @(negedge clk);
        ctl_write(8'h83, 8'hFF);
        chk("R12 sel frozen", bus_rdata, 8'h80);
        measure_gap(g);
        chk("R12 period kept", g, 1);
        clkout_en = 1'b0;
        ctl_write(8'h00, 8'hFF);
        chk("R12 released", bus_rdata, 8'h00);
    endtask

    task automatic t_guard;
        bus_cycle(1'b1, 1'b0, 1'b0, 8'h05, 8'h0F);
        chk("R9 unkeyed dropped", bus_rdata, 8'h00);
        chk("R9 err set", prot_err, 1);
        bus_cycle(1'b1, 1'b0, 1'b1, 8'h00, 8'h00);
        bus_cycle(1'b0, 1'b1, 1'b1, 8'h00, 8'h00);
        bus_cycle(1'b1, 1'b0, 1'b0, 8'h05, 8'h0F);
        chk("R10 disarmed write dropped", bus_rdata, 8'h00);
        ctl_write(8'h05, 8'h0F);
        chk("R9 keyed write ok", bus_rdata, 8'h05);
        chk("R9 err sticky", prot_err, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_divs;
        t_prohibited;
        t_bitwise;
        t_subclock;
        t_boundary;
        t_clkout;
        t_guard;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule